// File: doc/BRIEF.md
# BCD Calendar Timekeeper Core

This block keeps wall-clock time and date as packed BCD bytes: seconds, minutes, hours (24-hour), day of month, month, two-digit year and a weekday number. An external one-second pulse advances the count while the run bit in the control register is set. The count handles every calendar carry, including month lengths and a 29-day February in years divisible by four.

Software reaches the block through one byte-wide register port. A single address bus serves both a write-data path and a registered read-data path. To set the clock, software first halts it, then loads the seven time bytes, then restarts it. To read a coherent time, software writes the snapshot bit. This freezes a copy of all counters in a shadow bank, and with the shadow-select bit set the time reads return that frozen copy. A one-shot rounding bit snaps the seconds to the nearest whole minute.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the time reads as seconds 0x00, minutes 0x00, hours 0x00, day 0x01, month 0x01, year 0x00, weekday 0x00, and the control register (offset 0x0D) reads 0x00.
- R2: Each one-cycle pulse on `tick_1s` with the run bit set advances seconds by one in BCD. Seconds 0x59 wraps to 0x00 and carries into minutes, minutes 0x59 wraps and carries into hours, and hours 0x23 wraps to 0x00 and carries into the day.
- R3: A day carry from the last day of the month sets the day to 0x01 and advances the month. The last day is 0x31 for months 01, 03, 05, 07, 08, 10 and 12, and 0x30 for months 04, 06, 09 and 11. For month 02 it is 0x29 when the year value is divisible by 4 and 0x28 otherwise. Month 0x12 wraps to 0x01 and advances the year, and year 0x99 wraps to 0x00.
- R4: Every day carry advances the weekday, and weekday 0x06 wraps to 0x00.
- R5: Bit 0 of the control register is the run bit. While it is 0, tick pulses leave all time registers unchanged.
- R6: The time registers sit at offsets 0x00 to 0x06 in the order seconds, minutes, hours, day, month, year, weekday. A write there loads the byte only while the run bit is 0, and is ignored while it is 1.
- R7: Writing the control register with bit 6 set copies all seven live counters into the shadow bank. Bit 6 then clears on the next cycle, so later reads of the control register show it as 0. The shadow bank is not changed by anything else.
- R8: Control bit 7 selects the source of time reads: 1 returns the shadow bank and 0 returns the live counters.
- R9: Writing control bit 1 rounds once. If seconds are 0x30 or more, the minutes advance with the full carry chain; in either case seconds become 0x00. Rounding works whether or not the run bit is set, and bit 1 then reads back as 0.
- R10: Control bits 2, 3, 4 and 5 are stored and read back as written, but have no effect. In particular hours continue past 0x12 to 0x13.
- R11: `rd_data` shows the register selected by `addr` one clock after `addr` is applied, and unmapped offsets read 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1s | input | 1 | One-cycle pulse per second |
| addr | input | ADDR_W | Register offset for reads and writes |
| wr_en | input | 1 | Write strobe for the addressed register |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Registered read data |

## Verification
A wrong carry condition or a wrong month-length entry corrupts the next field up on the tick that should have rolled over. That error is visible in the very next register read, one clock later. The bench therefore loads the last second of every month across leap and common years and reads the whole date back after one tick. A stale or unguarded shadow bank shows up as a time read that disagrees with the live value after the snapshot bit is toggled. A sticky one-shot bit shows up at once in the control read-back, or as repeated rounding.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam int unsigned NUM_FIELDS = 7;
  localparam int unsigned IDX_W      = 3;

  typedef struct packed {
    logic [7:0] sec;
    logic [7:0] min;
    logic [7:0] hr;
    logic [7:0] day;
    logic [7:0] mon;
    logic [7:0] yr;
    logic [7:0] wday;
  } cal_t;

  localparam cal_t CAL_RESET = '{sec: 8'h00, min: 8'h00, hr: 8'h00, day: 8'h01,
                                 mon: 8'h01, yr: 8'h00, wday: 8'h00};

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [7:0] field_of(input cal_t c, input logic [IDX_W-1:0] idx);
    case (idx)
      3'd0:    return c.sec;
      3'd1:    return c.min;
      3'd2:    return c.hr;
      3'd3:    return c.day;
      3'd4:    return c.mon;
      3'd5:    return c.yr;
      3'd6:    return c.wday;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/rtc_month_len.sv
module rtc_month_len (
  input  logic [7:0] mon_bcd,
  input  logic [7:0] yr_bcd,
  output logic [7:0] last_day
);
  logic [6:0] yr_bin;
  logic       leap;

  always_comb begin
    yr_bin = 7'(yr_bcd[7:4]) * 7'd10 + 7'(yr_bcd[3:0]);
    leap   = (yr_bin[1:0] == 2'b00);
    case (mon_bcd)
      8'h02:                      last_day = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
      default:                    last_day = 8'h31;
    endcase
  end
endmodule

// File: rtl/rtc_cal_counter.sv
module rtc_cal_counter
  import rtc_cal_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             round_req,
  input  logic             load_en,
  input  logic [IDX_W-1:0] load_idx,
  input  logic [7:0]       load_data,
  input  logic [7:0]       last_day,
  output cal_t             now
);
  cal_t nxt;
  logic c_min, c_hr, c_day, c_mon, c_yr;

  always_comb begin
    nxt   = now;
    c_min = round_req ? (now.sec >= 8'h30) : (step && now.sec == 8'h59);
    c_hr  = c_min && now.min == 8'h59;
    c_day = c_hr  && now.hr  == 8'h23;
    c_mon = c_day && now.day == last_day;
    c_yr  = c_mon && now.mon == 8'h12;

    if (round_req)  nxt.sec = 8'h00;
    else if (step)  nxt.sec = (now.sec == 8'h59) ? 8'h00 : bcd_inc(now.sec);

    if (c_min) nxt.min = (now.min == 8'h59) ? 8'h00 : bcd_inc(now.min);
    if (c_hr)  nxt.hr  = (now.hr  == 8'h23) ? 8'h00 : bcd_inc(now.hr);
    if (c_day) begin
      nxt.day  = (now.day == last_day) ? 8'h01 : bcd_inc(now.day);
      nxt.wday = (now.wday == 8'h06) ? 8'h00 : now.wday + 8'h01;
    end
    if (c_mon) nxt.mon = (now.mon == 8'h12) ? 8'h01 : bcd_inc(now.mon);
    if (c_yr)  nxt.yr  = (now.yr  == 8'h99) ? 8'h00 : bcd_inc(now.yr);

    if (!round_req && !step && load_en) begin
      case (load_idx)
        3'd0:    nxt.sec  = load_data;
        3'd1:    nxt.min  = load_data;
        3'd2:    nxt.hr   = load_data;
        3'd3:    nxt.day  = load_data;
        3'd4:    nxt.mon  = load_data;
        3'd5:    nxt.yr   = load_data;
        3'd6:    nxt.wday = load_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) now <= CAL_RESET;
    else     now <= nxt;
  end

  // R5: no step, round or load leaves every counter untouched
  a_r5_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!step && !round_req && !load_en) |=> $stable(now));

  // R9: rounding always leaves seconds at zero
  a_r9_round_zero: assert property (@(posedge clk) disable iff (rst)
    round_req |=> (now.sec == 8'h00));

  // R2: a tick below 59 seconds never touches the minutes
  a_r2_no_early_carry: assert property (@(posedge clk) disable iff (rst)
    (step && !round_req && now.sec != 8'h59) |=> $stable(now.min));
endmodule

// File: rtl/rtc_ctrl_regs.sv
module rtc_ctrl_regs
  import rtc_cal_pkg::*;
#(
  parameter int unsigned    ADDR_W    = 5,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 5'h0D
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wr_data,
  input  cal_t              now,
  output logic              run,
  output logic              round_req,
  output logic              load_en,
  output logic [IDX_W-1:0]  load_idx,
  output logic [7:0]        rd_data
);
  localparam int unsigned RUN_BIT   = 0;
  localparam int unsigned ROUND_BIT = 1;
  localparam int unsigned SNAP_BIT  = 6;
  localparam int unsigned SHSEL_BIT = 7;

  logic [7:0] ctrl_q;
  cal_t       shadow;
  logic       ctrl_wr, is_time, snap;

  always_comb begin
    ctrl_wr   = wr_en && (addr == CTRL_ADDR);
    is_time   = (addr < ADDR_W'(NUM_FIELDS));
    snap      = ctrl_wr && wr_data[SNAP_BIT];
    run       = ctrl_q[RUN_BIT];
    round_req = ctrl_q[ROUND_BIT];
    load_en   = wr_en && is_time && !ctrl_q[RUN_BIT];
    load_idx  = addr[IDX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= 8'h00;
    end else if (ctrl_wr) begin
      ctrl_q <= wr_data;
    end else begin
      ctrl_q[SNAP_BIT]  <= 1'b0;
      ctrl_q[ROUND_BIT] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       shadow <= CAL_RESET;
    else if (snap) shadow <= now;
  end

  always_ff @(posedge clk) begin
    if (rst)                     rd_data <= 8'h00;
    else if (is_time)            rd_data <= ctrl_q[SHSEL_BIT] ? field_of(shadow, load_idx)
                                                               : field_of(now, load_idx);
    else if (addr == CTRL_ADDR)  rd_data <= ctrl_q;
    else                         rd_data <= 8'h00;
  end

  // R7: snapshot bit never survives past one cycle without a new write
  a_r7_snap_selfclear: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[SNAP_BIT] && !(ctrl_wr && wr_data[SNAP_BIT])) |=> !ctrl_q[SNAP_BIT]);

  // R7: shadow bank only moves on a snapshot write
  a_r7_shadow_hold: assert property (@(posedge clk) disable iff (rst)
    !snap |=> $stable(shadow));

  // R9: rounding request is one-shot
  a_r9_round_oneshot: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[ROUND_BIT] && !(ctrl_wr && wr_data[ROUND_BIT])) |=> !ctrl_q[ROUND_BIT]);
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
  import rtc_cal_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 5,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 5'h0D
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_1s,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data
);
  cal_t             now;
  logic             run, round_req, load_en;
  logic [IDX_W-1:0] load_idx;
  logic [7:0]       last_day;

  rtc_ctrl_regs #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .now(now), .run(run), .round_req(round_req), .load_en(load_en),
    .load_idx(load_idx), .rd_data(rd_data)
  );

  rtc_month_len u_mlen (.mon_bcd(now.mon), .yr_bcd(now.yr), .last_day(last_day));

  rtc_cal_counter u_cnt (
    .clk(clk), .rst(rst), .step(tick_1s && run), .round_req(round_req),
    .load_en(load_en), .load_idx(load_idx), .load_data(wr_data),
    .last_day(last_day), .now(now)
  );

  // R6: loads are refused while the clock is running
  a_r6_no_load_running: assert property (@(posedge clk) disable iff (rst)
    (run && !round_req && !tick_1s) |=> $stable(now));
endmodule

// File: tb/test_rtc_calendar_core.sv
module test_rtc_calendar_core;
  logic       clk = 0, rst = 1, tick_1s = 0, wr_en = 0;
  logic [4:0] addr = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  int errors = 0, checks = 0;
  bit done = 0;
  int m[7];

  always #10 clk = ~clk;

  rtc_calendar_core i_rtc_calendar_core (
    .clk(clk), .rst(rst), .tick_1s(tick_1s), .addr(addr),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
  );

  function automatic int bcd(int v); return ((v / 10) << 4) | (v % 10); endfunction
  function automatic int dim(int mo, int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk); addr = 5'(a); wr_data = 8'(d); wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(int a, output int v);
    @(negedge clk); addr = 5'(a);
    @(negedge clk); v = rd_data;
  endtask

  task automatic tick();
    @(negedge clk); tick_1s = 1;
    @(negedge clk); tick_1s = 0;
  endtask

  // bench model of one second (binary fields)
  task automatic model_sec();
    m[0]++;
    if (m[0] == 60) begin m[0] = 0; m[1]++; end
    if (m[1] == 60) begin m[1] = 0; m[2]++; end
    if (m[2] == 24) begin
      m[2] = 0; m[6] = (m[6] + 1) % 7; m[3]++;
      if (m[3] > dim(m[4], m[5])) begin
        m[3] = 1; m[4]++;
        if (m[4] == 13) begin m[4] = 1; m[5] = (m[5] + 1) % 100; end
      end
    end
  endtask

  task automatic load_model();
    wr(13, 8'h00);
    for (int i = 0; i < 7; i++) wr(i, bcd(m[i]));
  endtask

  task automatic check_all(string req);
    int v;
    for (int i = 0; i < 7; i++) begin
      rd(i, v); chk(req, v, bcd(m[i]));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk); rst = 0;
    // R1 reset state
    m = '{0, 0, 0, 1, 1, 0, 0};
    check_all("R1");
    rd(13, v); chk("R1 ctrl", v, 8'h00);
    rd(5'h0A, v); chk("R11 unmapped", v, 8'h00);

    // R2 seconds/minutes sweep from 00:00:00
    wr(13, 8'h01);
    for (int k = 0; k < 130; k++) begin
      tick(); model_sec();
      rd(0, v); chk("R2 sec", v, bcd(m[0]));
      rd(1, v); chk("R2 min", v, bcd(m[1]));
    end

    // R3 R4 month-end sweep over leap and common years
    foreach (m[i]) m[i] = 0;
    for (int yi = 0; yi < 6; yi++) begin
      for (int mo = 1; mo <= 12; mo++) begin
        int yrs[6] = '{0, 1, 2, 3, 4, 99};
        m[5] = yrs[yi]; m[4] = mo; m[3] = dim(mo, m[5]);
        m[2] = 23; m[1] = 59; m[0] = 59; m[6] = (mo + yi) % 7;
        load_model();
        wr(13, 8'h01);
        tick(); model_sec();
        check_all("R3 R4 rollover");
      end
    end

    // R5 halted clock ignores ticks
    m = '{12, 34, 5, 6, 7, 8, 3};
    load_model();
    repeat (4) tick();
    check_all("R5 halted");

    // R6 loads ignored while running
    wr(13, 8'h01);
    wr(0, 8'h44); wr(2, 8'h11);
    check_all("R6 write ignored");

    // R7 R8 snapshot and source select
    wr(13, 8'hC1);
    rd(13, v); chk("R7 snap bit clear", v, 8'h81);
    for (int k = 0; k < 3; k++) tick();
    rd(0, v); chk("R8 shadow sec", v, 8'h12);
    wr(13, 8'h01);
    rd(0, v); chk("R8 live sec", v, 8'h15);
    wr(13, 8'h81);
    rd(0, v); chk("R7 shadow held", v, 8'h12);
    rd(6, v); chk("R7 shadow wday", v, 8'h03);

    // R9 round up with full carry, halted
    m = '{45, 59, 23, 31, 12, 99, 6};
    load_model();
    wr(13, 8'h02);
    m = '{0, 0, 0, 1, 1, 0, 0};
    check_all("R9 round up");
    rd(13, v); chk("R9 bit cleared", v, 8'h00);
    // R9 round down while running
    m = '{29, 10, 9, 15, 3, 21, 2};
    load_model();
    wr(13, 8'h03);
    m[0] = 0;
    check_all("R9 round down");
    rd(13, v); chk("R9 run kept", v, 8'h01);

    // R10 stored bits with no effect, hours pass 12
    m = '{59, 59, 12, 10, 10, 10, 1};
    load_model();
    wr(13, 8'h3D);
    tick(); model_sec();
    check_all("R10 24h");
    rd(13, v); chk("R10 readback", v, 8'h3D);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule